// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block turns single-cycle error and event pulses from the surrounding datapath into sticky flag bits. It drives one active-low interrupt request pin from the flags that the host has enabled. Three of the eight sources have fixed meanings:

- bit 0: the host wrote to the transmit data FIFO while it was full.
- bit 1: the transmit side read the transmit data FIFO while it was empty.
- bit 2: an arithmetic overflow occurred inside a FIR filter.

Bits 3 to 7 are general-purpose event inputs.

The host finds the cause of an interrupt by reading the flag register. It acknowledges a cause by writing a one to that flag bit. It chooses which sources may raise the pin by writing the enable register, and every source is disabled after reset. A mode bit in the control register hands the pin over to the internal symbol clock. Use this when devices must be aligned to the same symbol phase. Flag capture continues while the pin is handed over.

The host port is a plain register port. A write takes effect at the clock edge where `wr_en_i` is high. A read request at one edge returns its data with `rd_valid_o` at the next edge. The returned value is the register content before any write in the same cycle. Stream handshakes are not used, because the port never stalls: the block accepts every write and read in the cycle it is presented.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag, enable and control registers read 0, `irq_n_o` is high and `rd_valid_o` is low.
- R2: A one-cycle high on `evt_i[k]` sets flag bit k at that clock edge. Bit 0 is FIFO write-while-full, bit 1 is FIFO read-while-empty, bit 2 is filter overflow, and bits 3 to 7 are general-purpose.
- R3: A set flag stays set until the host writes address 0 with a one in that bit. Zero bits in that write leave their flags unchanged.
- R4: A flag whose enable bit is 0 still records its event, and it does not pull `irq_n_o` low.
- R5: With the control mode bit at 0, `irq_n_o` is low exactly when some flag bit and the same enable bit are both 1.
- R6: Writing an enable bit for a flag that is already set drives `irq_n_o` low immediately after that write's clock edge.
- R7: When an event pulse and a clear of the same bit arrive in the same cycle, the flag ends up set.
- R8: Address 1 is the enable register (1 = source enabled). It is read/write over all 8 bits.
- R9: Address 2 bit 0 is the mode bit, and the other control bits read 0. With the mode bit at 1, `irq_n_o` follows `sym_clk_i` combinationally, and flags keep being captured.
- R10: A read request at one clock edge gives `rd_valid_o` high for one cycle after that edge. The returned data is the register value before any write made in the same cycle.
- R11: Address 3 is unused. Writes to it change nothing, and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle event pulses, one per flag bit |
| sym_clk_i | input | 1 | Internal symbol-clock signal for pin routing |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read request |
| addr_i | input | 2 | Register address (0 flags, 1 enable, 2 control, 3 unused) |
| wdata_i | input | 8 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after request |
| rd_data_o | output | 8 | Read data |
| irq_n_o | output | 1 | Active-low interrupt request, or the symbol clock in mode 1 |

## Verification
Two functions can meet in one cycle: an event pulse and a host write-one-to-clear on the same flag bit. The bench provokes this directly. It also drives a long pseudo-random stream in which events, clears and reads overlap freely. The outcome is judged by the next flag read and by the interrupt level, which both show that the event won. A read of the flag register can also fall in the cycle of its own clear. The bench checks that such a read returns the value from before the clear.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned SRC_W  = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_FLAGS = 2'd0,
    REG_EN    = 2'd1,
    REG_CTRL  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned SRC_TXF_WR_FULL  = 0;
  localparam int unsigned SRC_TXF_RD_EMPTY = 1;
  localparam int unsigned SRC_FIR_OVF      = 2;
  localparam int unsigned CTRL_MODE_BIT    = 0;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  // One sticky cell per source; the set side wins over clear.
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cell_q <= 1'b0;
      else if (evt_i[i]) cell_q <= 1'b1;
      else if (clr_i[i]) cell_q <= 1'b0;
    end
    assign flags_o[i] = cell_q;
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_flag_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      flags_i,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      en_o,
  output logic              sym_mode_o,
  output logic              rd_valid_o,
  output logic [W-1:0]      rd_data_o
);
  reg_sel_e     sel;
  logic [W-1:0] en_q;
  logic         mode_q;
  logic [W-1:0] rd_mux;

  assign sel = reg_sel_e'(addr_i);

  assign clr_o = (wr_en_i && sel == REG_FLAGS) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= 1'b0;
    end else if (wr_en_i) begin
      if (sel == REG_EN)   en_q   <= wdata_i;
      if (sel == REG_CTRL) mode_q <= wdata_i[CTRL_MODE_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      REG_FLAGS: rd_mux = flags_i;
      REG_EN:    rd_mux = en_q;
      REG_CTRL:  rd_mux[CTRL_MODE_BIT] = mode_q;
      REG_NONE:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  assign en_o       = en_q;
  assign sym_mode_o = mode_q;
endmodule

// File: rtl/irq_pin_mux.sv
module irq_pin_mux #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] en_i,
  input  logic         sym_mode_i,
  input  logic         sym_clk_i,
  output logic         irq_n_o
);
  logic pending;
  assign pending = |(flags_i & en_i);
  assign irq_n_o = sym_mode_i ? sym_clk_i : ~pending;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned SRC_CNT = SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_CNT-1:0] evt_i,
  input  logic               sym_clk_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [SRC_CNT-1:0] wdata_i,
  output logic               rd_valid_o,
  output logic [SRC_CNT-1:0] rd_data_o,
  output logic               irq_n_o
);
  logic [SRC_CNT-1:0] flags_q;
  logic [SRC_CNT-1:0] clr_req;
  logic [SRC_CNT-1:0] en_q;
  logic               sym_mode;

  irq_flag_bank #(.W(SRC_CNT)) u_bank (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_req), .flags_o(flags_q)
  );

  irq_reg_file #(.W(SRC_CNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .flags_i(flags_q), .clr_o(clr_req),
    .en_o(en_q), .sym_mode_o(sym_mode), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o)
  );

  irq_pin_mux #(.W(SRC_CNT)) u_pin (
    .flags_i(flags_q), .en_i(en_q), .sym_mode_i(sym_mode),
    .sym_clk_i(sym_clk_i), .irq_n_o(irq_n_o)
  );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] evt_i,
  input logic         sym_clk_i,
  input logic         wr_en_i,
  input logic         rd_en_i,
  input logic [1:0]   addr_i,
  input logic [W-1:0] wdata_i,
  input logic         rd_valid_o,
  input logic         irq_n_o,
  input logic [W-1:0] flags_q,
  input logic [W-1:0] en_q,
  input logic         sym_mode
);
  logic [W-1:0] host_clr;
  assign host_clr = (wr_en_i && addr_i == 2'd0) ? wdata_i : '0;

  // R2: every pulsed source is set after the edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  // R3: a flag only falls where the host asked for a clear
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~flags_q & $past(flags_q) & ~$past(host_clr)) == '0));

  // R7: event beats a same-cycle clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_clr & evt_i) != '0) |=> ((flags_q & $past(host_clr & evt_i)) == $past(host_clr & evt_i)));

  // R4: nothing enabled and set means the pin stays high in interrupt mode
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_mode && (flags_q & en_q) == '0) |-> irq_n_o);

  // R9: symbol-clock mode passes the clock through
  a_r9_sym_route: assert property (@(posedge clk) disable iff (!rst_n)
    sym_mode |-> (irq_n_o == sym_clk_i));

  // R10: one valid cycle per read request
  a_r10_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.W(SRC_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sym_clk_i(sym_clk_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rd_valid_o(rd_valid_o), .irq_n_o(irq_n_o), .flags_q(flags_q),
  .en_q(en_q), .sym_mode(sym_mode)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       sym_clk_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       rd_valid_o;
  logic [7:0] rd_data_o;
  logic       irq_n_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_flags = '0, m_en = '0;
  logic       m_mode = 1'b0, m_rv = 1'b0;
  logic [7:0] m_rd = '0;

  always #(P/2) clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sym_clk_i(sym_clk_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_flags;
      2'd1: return m_en;
      2'd2: return {7'd0, m_mode};
      default: return 8'd0;
    endcase
  endfunction

  // Drive one cycle (called just after a negedge), update the model at the
  // posedge, then compare outputs a quarter period later.
  task automatic cyc(input string tag, input logic [7:0] evt, input logic wr,
                     input logic [1:0] a, input logic [7:0] d, input logic rd,
                     input logic sc);
    logic [7:0] clr;
    evt_i = evt; wr_en_i = wr; addr_i = a; wdata_i = d; rd_en_i = rd; sym_clk_i = sc;
    @(posedge clk);
    m_rv = rd;
    if (rd) m_rd = model_read(a);
    clr = (wr && a == 2'd0) ? d : 8'd0;
    if (wr && a == 2'd1) m_en = d;
    if (wr && a == 2'd2) m_mode = d[0];
    m_flags = (m_flags & ~clr) | evt;
    #(P/4);
    chk(tag, "rd_valid", int'(rd_valid_o), int'(m_rv));
    if (m_rv) chk(tag, "rd_data", int'(rd_data_o), int'(m_rd));
    chk(tag, "irq_n", int'(irq_n_o), int'(m_mode ? sc : ~|(m_flags & m_en)));
    @(negedge clk);
    evt_i = '0; wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a);
    cyc(tag, 8'd0, 1'b0, a, 8'd0, 1'b1, 1'b0);
    cyc(tag, 8'd0, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [7:0] d);
    cyc(tag, 8'd0, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1", "irq_n in reset", int'(irq_n_o), 1);
    chk("R1", "rd_valid in reset", int'(rd_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) rd("R1", 2'(a));

    // R2 / R4: each source singly, all masked
    for (int k = 0; k < 8; k++) cyc("R4", 8'(1 << k), 1'b0, 2'd0, 8'd0, 1'b0, 1'b0);
    rd("R2", 2'd0);
    // R3: partial clear, then a zero write
    wr("R3", 2'd0, 8'h0F);
    rd("R3", 2'd0);
    wr("R3", 2'd0, 8'h00);
    rd("R3", 2'd0);
    // R8: enable register readback
    wr("R8", 2'd1, 8'hA5);
    rd("R8", 2'd1);
    // R5 / R6: quiet, set while masked, unmask, clear
    wr("R5", 2'd1, 8'h00);
    wr("R5", 2'd0, 8'hFF);
    cyc("R4", 8'h20, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0);
    wr("R6", 2'd1, 8'h20);
    wr("R5", 2'd0, 8'h20);
    // R7: event and clear on the same bit
    wr("R7", 2'd1, 8'h04);
    cyc("R7", 8'h04, 1'b1, 2'd0, 8'h04, 1'b0, 1'b0);
    rd("R7", 2'd0);
    // R10: read in the cycle of its own clear returns old value
    cyc("R10", 8'd0, 1'b1, 2'd0, 8'h04, 1'b1, 1'b0);
    rd("R10", 2'd0);
    // R11: unused address
    wr("R11", 2'd3, 8'hFF);
    for (int a = 0; a < 4; a++) rd("R11", 2'(a));
    // R9: hand the pin to the symbol clock, events still captured
    wr("R9", 2'd1, 8'hFF);
    wr("R9", 2'd2, 8'hFF);
    rd("R9", 2'd2);
    for (int i = 0; i < 8; i++)
      cyc("R9", (i == 3) ? 8'h80 : 8'h00, 1'b0, 2'd0, 8'd0, 1'b0, 1'(i % 2));
    wr("R9", 2'd2, 8'h00);
    rd("R9", 2'd0);
    // R5: pseudo-random mixture
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R5", (lfsr[3:0] == 4'd0) ? 8'(1 << lfsr[6:4]) : 8'd0,
          lfsr[7] & lfsr[8], lfsr[10:9], {lfsr[15:12], lfsr[3:0]},
          lfsr[11], lfsr[1]);
    end
    rd("R5", 2'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(P * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule